// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the fetch side of a transmit path. Software places frames in a ring of 128-byte entries and moves a write pointer forward. The engine handles each entry from its own read pointer up to that write pointer. It reads the entry's command word. It streams the inline payload stored inside the entry, then up to three external scatter buffers, one byte at a time to a MAC. It waits for the MAC's verdict on the frame, writes a status word over the command word, and only then advances the read pointer.

The memory side is a single 64-bit word port. A request is held until it is acknowledged, and read data arrives with the acknowledge. Memory bytes are big-endian within a word: byte k of a word sits in bits [63-8k:56-8k]. A frame whose transmission aborts can, when its entry asks for it, stop the engine for good. Only a reset recovers it.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset, rd_ptr is 0 and halted, pkt_sent, tx_abort, mem_req and tx_valid are all low.
- R2: ring_empty is high exactly when rd_ptr equals wr_ptr, and while they are equal the engine issues no memory request.
- R3: Entry n starts at byte address RING_BASE + 128*n. Its command word at that address is read first, and the status word is written back to that same address.
- R4: The command word gives the inline byte count minus one in bits [15:0] and the inline start offset, counted from the entry start, in bits [22:16]. The inline bytes are sent first, in ascending address order, whatever the offset alignment.
- R5: Command bits 25, 26 and 27 mark scatter pointers 1, 2 and 3 as valid. Pointer k is the entry's word k, at byte offset 8k. It holds the buffer length minus one in bits [47:32] and the word address of the buffer in bits [31:3]. Valid buffers are sent after the inline bytes, in order 1, 2, 3.
- R6: tx_last is high on the final byte of a frame and on no other byte.
- R7: After the MAC result, the status word has bit 63 set, bits [15:0] equal to the number of bytes sent, bits [19:16] equal to the retry count, bit 23 equal to success, and bits [28:24] equal to the abort reason when the frame failed. All other bits are zero. Reason bits: 24 too long, 25 underrun, 26 excess collisions, 27 excess deferrals, 28 late collision.
- R8: rd_ptr advances by one, modulo RING_ENTRIES, only on the cycle after the status write is acknowledged.
- R9: pkt_sent pulses for one cycle after the status write of a frame whose command bit 24 is set and whose result is success.
- R10: tx_abort pulses for one cycle after the status write of a failed frame. If that frame's command bit 23 is set, halted rises and stays high, and no further memory request or byte is issued.
- R11: A memory request keeps its address and direction stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr | input | PTR_W | Host write pointer: index of the first entry not yet queued |
| rd_ptr | output | PTR_W | Index of the next entry to be processed |
| ring_empty | output | 1 | High when rd_ptr equals wr_ptr |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | 32 | Byte address, word-aligned for all accesses |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Byte available to the MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte this cycle |
| res_valid | input | 1 | One-cycle MAC verdict for the current frame |
| res_ok | input | 1 | Frame sent successfully |
| res_abort | input | 5 | Abort reason, in R7 bit order |
| res_retry | input | 4 | Collision retry count |
| pkt_sent | output | 1 | Per-frame sent indication pulse |
| tx_abort | output | 1 | Aborted frame pulse |
| halted | output | 1 | Engine stopped after a terminating abort |

## Verification
The assertions assume a well-behaved environment. mem_ack rises only while a request is pending and lasts one cycle. res_valid arrives once per frame, only after the last byte has been accepted. wr_ptr never runs more than a ring's worth ahead of rd_ptr. The stimulus keeps to these rules in three ways. Its memory responder acknowledges each pending request once, after a random delay of zero to two cycles. Its MAC model pulses a verdict a few cycles after it sees tx_last. Frames are queued in batches of one to three, and the bench waits for the ring to drain before the next batch. Inline offsets are drawn at 32 or above, so inline data never overlaps the pointer words, and the inline bytes always end inside the entry.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_PTR, ST_WORD, ST_EMIT, ST_WAIT, ST_STAT, ST_HALT
    } eng_state_e;

    localparam int CMD_OFF_LO  = 16;
    localparam int CMD_TERM    = 23;
    localparam int CMD_INT     = 24;
    localparam int CMD_VLD_LO  = 25;
    localparam int STS_OK      = 23;

    function automatic logic [63:0] make_status(input logic ok, input logic [4:0] why,
                                                input logic [3:0] tries, input logic [15:0] nbytes);
        logic [63:0] s;
        s        = '0;
        s[63]    = 1'b1;
        s[28:24] = ok ? 5'd0 : why;
        s[STS_OK]= ok;
        s[19:16] = tries;
        s[15:0]  = nbytes;
        return s;
    endfunction

endpackage

// File: rtl/tx_byte_lane.sv
module tx_byte_lane #(
    parameter int LANES = 8
) (
    input  logic [8*LANES-1:0]       word_i,
    input  logic [$clog2(LANES)-1:0] sel_i,
    output logic [7:0]               byte_o
);
    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[8*LANES-1-8*g -: 8];
    end

    assign byte_o = lane[sel_i];
endmodule

// File: rtl/tx_seg_next.sv
module tx_seg_next #(
    parameter int N_PTR = 3,
    localparam int IW   = $clog2(N_PTR + 1)
) (
    input  logic [N_PTR-1:0] vld_i,
    input  logic [IW-1:0]    cur_i,
    output logic             has_o,
    output logic [IW-1:0]    nxt_o
);
    always_comb begin
        has_o = 1'b0;
        nxt_o = '0;
        for (int k = N_PTR; k >= 1; k--) begin
            if (vld_i[k-1] && (k > int'(cur_i))) begin
                has_o = 1'b1;
                nxt_o = IW'(k);
            end
        end
    end
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int          RING_ENTRIES = 64,
    parameter logic [31:0] RING_BASE    = 32'h0,
    localparam int         PTR_W        = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1,
    localparam int         N_PTR        = 3,
    localparam int         IW           = $clog2(N_PTR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             ring_empty,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [63:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [63:0]      mem_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             tx_ready,
    input  logic             res_valid,
    input  logic             res_ok,
    input  logic [4:0]       res_abort,
    input  logic [3:0]       res_retry,
    output logic             pkt_sent,
    output logic             tx_abort,
    output logic             halted
);
    typedef struct packed {
        eng_state_e       st;
        logic [PTR_W-1:0] rd;
        logic [N_PTR-1:0] vld;
        logic             want_int;
        logic             want_term;
        logic [31:0]      addr;
        logic [15:0]      cnt;
        logic [63:0]      word;
        logic [IW-1:0]    seg;
        logic [15:0]      tot;
        logic [63:0]      stat;
        logic             sent;
        logic             abrt;
        logic             halt;
    } regs_t;

    regs_t q, d;

    logic [31:0]      entry_a;
    logic [PTR_W-1:0] rd_inc;
    logic             has_next;
    logic [IW-1:0]    nxt_seg;
    logic [7:0]       cur_byte;
    logic             seg_end;
    logic             unused_bits;

    assign entry_a     = RING_BASE + (32'(q.rd) << 7);
    assign rd_inc      = (q.rd == PTR_W'(RING_ENTRIES - 1)) ? '0 : q.rd + 1'b1;
    assign seg_end     = (q.cnt == 16'd0);
    assign unused_bits = ^{mem_rdata[63:48], mem_rdata[2:0]};

    tx_byte_lane #(.LANES(8)) u_lane (
        .word_i(q.word), .sel_i(q.addr[2:0]), .byte_o(cur_byte)
    );

    tx_seg_next #(.N_PTR(N_PTR)) u_next (
        .vld_i(q.vld), .cur_i(q.seg), .has_o(has_next), .nxt_o(nxt_seg)
    );

    always_comb begin
        d       = q;
        d.sent  = 1'b0;
        d.abrt  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = entry_a;
        mem_wdata = q.stat;
        tx_valid  = 1'b0;
        tx_data   = cur_byte;
        tx_last   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (q.rd != wr_ptr) d.st = ST_HDR;
            end
            ST_HDR: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    d.vld       = mem_rdata[CMD_VLD_LO +: N_PTR];
                    d.want_int  = mem_rdata[CMD_INT];
                    d.want_term = mem_rdata[CMD_TERM];
                    d.addr      = entry_a + 32'(mem_rdata[CMD_OFF_LO +: 7]);
                    d.cnt       = mem_rdata[15:0];
                    d.seg       = '0;
                    d.tot       = '0;
                    d.st        = ST_WORD;
                end
            end
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = entry_a + (32'(q.seg) << 3);
                if (mem_ack) begin
                    d.addr = {mem_rdata[31:3], 3'b000};
                    d.cnt  = mem_rdata[47:32];
                    d.st   = ST_WORD;
                end
            end
            ST_WORD: begin
                mem_req  = 1'b1;
                mem_addr = {q.addr[31:3], 3'b000};
                if (mem_ack) begin
                    d.word = mem_rdata;
                    d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                tx_valid = 1'b1;
                tx_last  = seg_end && !has_next;
                if (tx_ready) begin
                    d.addr = q.addr + 32'd1;
                    d.cnt  = q.cnt - 16'd1;
                    d.tot  = q.tot + 16'd1;
                    if (seg_end) begin
                        if (has_next) begin
                            d.seg = nxt_seg;
                            d.st  = ST_PTR;
                        end else begin
                            d.st  = ST_WAIT;
                        end
                    end else if (q.addr[2:0] == 3'd7) begin
                        d.st = ST_WORD;
                    end
                end
            end
            ST_WAIT: begin
                if (res_valid) begin
                    d.stat = make_status(res_ok, res_abort, res_retry, q.tot);
                    d.st   = ST_STAT;
                end
            end
            ST_STAT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    d.rd   = rd_inc;
                    d.sent = q.want_int && q.stat[STS_OK];
                    d.abrt = !q.stat[STS_OK];
                    if (!q.stat[STS_OK] && q.want_term) begin
                        d.halt = 1'b1;
                        d.st   = ST_HALT;
                    end else begin
                        d.st   = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_ptr     = q.rd;
    assign ring_empty = (q.rd == wr_ptr);
    assign pkt_sent   = q.sent;
    assign tx_abort   = q.abrt;
    assign halted     = q.halt;

    // R11: a pending request does not move
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: read pointer moves only after an acknowledged write, by one step
    p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_ptr) |-> ($past(mem_ack && mem_we) && rd_ptr == $past(rd_inc)));

    // R2: nothing is fetched from an empty ring
    p_empty_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !mem_req);

    // R6: the last byte ends streaming
    p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    // R9: sent indication is a single pulse
    p_sent_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_sent |=> !pkt_sent);

    // R10: halt is sticky and silent
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !tx_valid));
endmodule

// File: tb/tx_ring_engine_tb.sv
`timescale 1ns/1ps
module tx_ring_engine_tb;
    localparam int ENT = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  wr_ptr;
    logic [5:0]  rd_ptr;
    logic        ring_empty, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic        res_valid, res_ok;
    logic [4:0]  res_abort;
    logic [3:0]  res_retry;
    logic        pkt_sent, tx_abort, halted;

    always #4 clk = ~clk;

    tx_ring_engine #(.RING_ENTRIES(ENT), .RING_BASE(32'h0)) u_dut (
        .clk, .rst_n, .wr_ptr, .rd_ptr, .ring_empty, .mem_req, .mem_we, .mem_addr,
        .mem_wdata, .mem_ack, .mem_rdata, .tx_valid, .tx_data, .tx_last, .tx_ready,
        .res_valid, .res_ok, .res_abort, .res_retry, .pkt_sent, .tx_abort, .halted
    );

    logic [63:0] mem [4096];
    int          checks = 0, errors = 0;
    bit          done = 0;
    logic [7:0]  exp_q[$], cap_q[$];
    bit          capl_q[$];
    int          waddr_q[$];
    int          exp_n[256], exp_e[256], exp_m[256];
    logic [63:0] exp_s[256];
    bit          r_ok[256];
    logic [4:0]  r_ab[256];
    logic [3:0]  r_rt[256];
    int          mac_f = 0, f_next = 0, f_chk = 0;
    int          n_sent = 0, n_abrt = 0, e_sent = 0, e_abrt = 0, req_seen = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input int a, input logic [7:0] v);
        mem[a >> 3][63 - 8*(a % 8) -: 8] = v;
    endtask

    function automatic logic [63:0] status_of(input bit ok, input logic [4:0] ab,
                                              input logic [3:0] rt, input int n);
        return {1'b1, 34'd0, ok ? 5'd0 : ab, ok, 3'd0, rt, 16'(n)};
    endfunction

    // memory responder
    initial begin
        bit pend = 0;
        int dly = 0;
        logic [31:0] paddr = 0;
        mem_ack = 0; mem_rdata = 0;
        forever begin
            @(negedge clk);
            if (mem_req) req_seen++;
            if (mem_ack) begin
                mem_ack = 0; pend = 0;
            end else if (mem_req) begin
                if (!pend) begin
                    pend = 1; paddr = mem_addr; dly = $urandom % 3;
                end
                if (dly == 0) begin
                    chk(mem_addr == paddr, "R11 request address moved", mem_addr, paddr);
                    mem_rdata = mem[mem_addr[14:3]];
                    if (mem_we) begin
                        mem[mem_addr[14:3]] = mem_wdata;
                        waddr_q.push_back(int'(mem_addr));
                    end
                    mem_ack = 1;
                end else dly--;
            end
        end
    end

    // MAC model
    initial begin
        int pend = 0;
        tx_ready = 0; res_valid = 0; res_ok = 0; res_abort = 0; res_retry = 0;
        forever begin
            @(negedge clk);
            res_valid = 0;
            if (pkt_sent) n_sent++;
            if (tx_abort) n_abrt++;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    res_valid = 1; res_ok = r_ok[mac_f];
                    res_abort = r_ab[mac_f]; res_retry = r_rt[mac_f];
                    mac_f++;
                end
            end
            tx_ready = ($urandom % 4) != 0;
            if (tx_valid && tx_ready) begin
                cap_q.push_back(tx_data);
                capl_q.push_back(tx_last);
                if (tx_last) pend = 1 + $urandom % 3;
            end
        end
    end

    task automatic fill(input int e, input logic [2:0] mask, input bit intf, input bit term,
                        input int off, input int nin, input bit ok, input logic [4:0] ab);
        int f = f_next;
        int tot;
        logic [3:0] rt = 4'($urandom);
        for (int w = 0; w < 16; w++) mem[e*16 + w] = 64'd0;
        tot = nin;
        for (int j = 0; j < nin; j++) begin
            logic [7:0] v = 8'($urandom);
            put_byte(e*128 + off + j, v);
            exp_q.push_back(v);
        end
        for (int k = 0; k < 3; k++) begin
            if (mask[k]) begin
                int bl = 1 + $urandom % 100;
                int ba = (1024 + e*48 + k*16) * 8;
                mem[e*16 + k + 1] = {16'd0, 16'(bl - 1), 32'(ba)};
                for (int j = 0; j < bl; j++) begin
                    logic [7:0] v = 8'($urandom);
                    put_byte(ba + j, v);
                    exp_q.push_back(v);
                end
                tot += bl;
            end
        end
        mem[e*16] = {36'd0, mask, intf, term, 7'(off), 16'(nin - 1)};
        exp_n[f] = tot; exp_e[f] = e; exp_m[f] = int'(mask);
        r_ok[f] = ok; r_ab[f] = ok ? 5'd0 : ab; r_rt[f] = rt;
        exp_s[f] = status_of(ok, ab, rt, tot);
        if (intf && ok) e_sent++;
        if (!ok) e_abrt++;
        f_next++;
    endtask

    task automatic fill_rand(input int e);
        int off = 32 + $urandom % 90;
        int nin = 1 + $urandom % (128 - off);
        bit ok = ($urandom % 5) != 0;
        logic [4:0] ab = 5'b1 << ($urandom % 5);
        fill(e, 3'($urandom), 1'($urandom), 1'b0, off, nin, ok, ab);
    endtask

    task automatic drain();
        while (rd_ptr != wr_ptr) @(negedge clk);
        repeat (4) @(negedge clk);
        while (f_chk < f_next) begin
            int f = f_chk;
            int berr = 0, lerr = 0;
            for (int j = 0; j < exp_n[f]; j++) begin
                logic [7:0] b, x;
                bit l;
                x = exp_q.pop_front();
                if (cap_q.size() == 0) begin berr++; lerr++; end
                else begin
                    b = cap_q.pop_front(); l = capl_q.pop_front();
                    if (b != x) berr++;
                    if (l != (j == exp_n[f] - 1)) lerr++;
                end
            end
            if (exp_m[f] == 0) chk(berr == 0, "R4 inline bytes", berr, 0);
            else               chk(berr == 0, "R5 gathered bytes", berr, 0);
            chk(lerr == 0, "R6 last flag placement", lerr, 0);
            chk(mem[exp_e[f]*16] == exp_s[f], "R7 status word", mem[exp_e[f]*16], exp_s[f]);
            if (waddr_q.size() == 0) chk(0, "R3 status address", -1, exp_e[f]*128);
            else begin
                int a = waddr_q.pop_front();
                chk(a == exp_e[f]*128, "R3 status address", a, exp_e[f]*128);
            end
            f_chk++;
        end
        chk(cap_q.size() == 0, "R6 extra bytes", cap_q.size(), 0);
        chk(n_sent == e_sent, "R9 sent pulses", n_sent, e_sent);
        chk(n_abrt == e_abrt, "R10 abort pulses", n_abrt, e_abrt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int total;
        int req0;
        void'($urandom(32'd2024));
        rst_n = 0; wr_ptr = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(rd_ptr == 0 && !halted && !pkt_sent && !tx_abort, "R1 reset outputs", rd_ptr, 0);
        chk(!mem_req && !tx_valid, "R1 reset idle", {mem_req, tx_valid}, 0);
        rst_n = 1;
        repeat (10) @(negedge clk);
        chk(req_seen == 0, "R2 no fetch when empty", req_seen, 0);
        chk(ring_empty == 1, "R2 empty flag", ring_empty, 1);

        // R4: unaligned inline only
        fill(0, 3'b000, 1'b0, 1'b0, 33, 10, 1'b1, 5'd0);
        wr_ptr = 1;
        @(negedge clk);
        chk(ring_empty == 0, "R2 empty flag low", ring_empty, 0);
        drain();
        chk(rd_ptr == 1, "R8 pointer step", rd_ptr, 1);

        // R5, R9: all pointers, interrupt requested
        fill(1, 3'b111, 1'b1, 1'b0, 100, 28, 1'b1, 5'd0);
        wr_ptr = 2;
        drain();

        // R10: abort without terminate, single inline byte, pointer 2 only
        fill(2, 3'b010, 1'b1, 1'b0, 37, 1, 1'b0, 5'b00100);
        wr_ptr = 3;
        drain();
        chk(halted == 0, "R10 no halt without terminate", halted, 0);

        // random batches across the wrap
        total = 3;
        while (total < 72) begin
            int k = 1 + $urandom % 3;
            for (int i = 0; i < k; i++) fill_rand((total + i) % ENT);
            total += k;
            wr_ptr = 6'(total % ENT);
            drain();
        end
        chk(rd_ptr == 6'(total % ENT), "R8 wrap modulo ring", rd_ptr, total % ENT);

        // R10: terminating abort
        fill(total % ENT, 3'b001, 1'b0, 1'b1, 64, 5, 1'b0, 5'b10000);
        total++;
        wr_ptr = 6'(total % ENT);
        drain();
        chk(halted == 1, "R10 halted after terminate", halted, 1);
        fill(total % ENT, 3'b000, 1'b0, 1'b0, 40, 4, 1'b1, 5'd0);
        req0 = req_seen;
        wr_ptr = 6'((total + 1) % ENT);
        repeat (40) @(negedge clk);
        chk(req_seen == req0, "R10 no fetch when halted", req_seen - req0, 0);
        chk(rd_ptr == 6'(total % ENT), "R10 pointer frozen", rd_ptr, total % ENT);
        chk(ring_empty == 0, "R2 empty low while halted", ring_empty, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule